// File: doc/BRIEF.md
# Inter-Processor Mailbox Slot Registers

This block holds a bank of mailbox slots through which two processor cores pass fixed-length messages. Every slot owns one mode word and a short run of message words. All of them sit behind a plain 32-bit register port that carries a word address, a write enable, write data and registered read data.

The sending core claims a slot and fills in its message words. It then signals the peer through a separate interrupt block that is not part of this design. The mode word holds a one-hot ownership state field and an acknowledge-mode bit. When the peer side pulses its per-slot acknowledge strobe, the acknowledge-mode bit decides what happens:
- With automatic acknowledge, the slot drops back to idle by itself.
- Otherwise, the slot is parked in the acknowledge state and a one-cycle event is raised for the interrupt logic.

A sender that polls watches a per-slot done flag, which is high whenever the slot's state reads exactly idle.

Top module: `mbox_slot_regs`

## Requirements
- R1: The word address is {slot, word}, where the upper bits select the slot and the low 4 bits select the word inside the 16-word window. Word 0 is the mode word, and words 1 to 8 are message words 0 to 7.
- R2: Message words store whatever is written and return it on `bus_rdata` on the clock edge after the address is presented.
- R3: The mode word stores all 32 written bits. The state field is bits 7:4 (idle 0x1, transmit 0x2, receive 0x4, acknowledge 0x8) and bit 0 is the acknowledge mode (1 automatic, 0 interrupt). A read-modify-write of one field therefore leaves every other bit as it was.
- R4: After reset every mode word reads 0x00000010, every message word reads 0, `ack_evt` is all zero and `tx_done` is all ones.
- R5: When `peer_ack[k]` is high and slot k has bit 0 set, the state field of slot k reads 0x1 after the next edge. All other bits stay unchanged and `ack_evt[k]` stays low.
- R6: When `peer_ack[k]` is high and slot k has bit 0 clear, the state field becomes 0x8 at the next edge. At the same edge `ack_evt[k]` goes high, and it stays high for exactly that one cycle.
- R7: `tx_done[k]` is high exactly when the state field of slot k equals 0x1.
- R8: Words 9 to 15 of any window read as 0, and writes to them change no stored value.
- R9: If a bus write to the mode word of slot k and `peer_ack[k]` occur in the same cycle, the written value is kept except for bits 7:4. Those bits take the acknowledge result, which is chosen by the acknowledge-mode bit held before the write.
- R10: A write to one slot changes no word of any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | log2(NUM_SLOTS)+4 | Word address {slot, word} |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| peer_ack | input | NUM_SLOTS | Per-slot acknowledge strobe from the peer |
| ack_evt | output | NUM_SLOTS | One-cycle acknowledge event per slot |
| tx_done | output | NUM_SLOTS | Slot state is idle |

## Verification
Three results have fixed timing after their stimulus:
- Read data belongs to the address presented in the cycle before the edge at which it appears.
- A write or acknowledge strobe updates the state field and `ack_evt` at the very next edge.
- `tx_done` follows the state field with no further delay.

The bench drives every input just after a falling edge. A behavioural model advances on the rising edge, and each output is compared against the model on the following falling edge, which is exactly one register stage after the stimulus. Directed reads use the same single-edge spacing to check the simultaneous write-and-acknowledge case and the unused words.

// File: rtl/mbox_slot_regs.sv
module mbox_slot_regs #(
  parameter int NUM_SLOTS = 32,
  parameter int MSG_WORDS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(NUM_SLOTS)+3:0]   bus_addr,
  input  logic                           bus_we,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_SLOTS-1:0]           peer_ack,
  output logic [NUM_SLOTS-1:0]           ack_evt,
  output logic [NUM_SLOTS-1:0]           tx_done
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int IDX_W  = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;
  localparam logic [3:0]  ST_IDLE  = 4'h1;
  localparam logic [3:0]  ST_ACK   = 4'h8;
  localparam logic [31:0] MODE_RST = {24'h0, ST_IDLE, 4'h0};

  wire [SLOT_W-1:0] a_slot = bus_addr[SLOT_W+3:4];
  wire [3:0]        a_word = bus_addr[3:0];
  wire              a_mode = (a_word == 4'd0);
  wire              a_data = (a_word != 4'd0) && (int'(a_word) <= MSG_WORDS);
  wire [IDX_W-1:0]  a_idx  = IDX_W'(a_word - 4'd1);

  logic [31:0] mode_q [NUM_SLOTS];
  logic [31:0] mode_d [NUM_SLOTS];
  logic [31:0] data_q [NUM_SLOTS][MSG_WORDS];
  logic [NUM_SLOTS-1:0] auto_ack;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign auto_ack[s] = mode_q[s][0];
    assign tx_done[s]  = (mode_q[s][7:4] == ST_IDLE);

    a_r5_auto_ack_idles: assert property (@(posedge clk) disable iff (!rst_n)
      peer_ack[s] && mode_q[s][0] |=> (mode_q[s][7:4] == ST_IDLE) && !ack_evt[s]);

    a_r6_irq_ack_parks: assert property (@(posedge clk) disable iff (!rst_n)
      peer_ack[s] && !mode_q[s][0] |=> (mode_q[s][7:4] == ST_ACK) && ack_evt[s]);

    a_r6_evt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt[s] |-> $past(peer_ack[s]) && !$past(mode_q[s][0]));
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      mode_d[s] = mode_q[s];
      if (bus_we && a_mode && (a_slot == SLOT_W'(s)))
        mode_d[s] = bus_wdata;
      if (peer_ack[s])
        mode_d[s][7:4] = mode_q[s][0] ? ST_IDLE : ST_ACK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) mode_q[s] <= MODE_RST;
      ack_evt <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) mode_q[s] <= mode_d[s];
      ack_evt <= peer_ack & ~auto_ack;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int w = 0; w < MSG_WORDS; w++)
          data_q[s][w] <= '0;
    end else if (bus_we && a_data) begin
      data_q[a_slot][a_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (a_mode) bus_rdata <= mode_q[a_slot];
    else if (a_data) bus_rdata <= data_q[a_slot][a_idx];
    else             bus_rdata <= '0;
  end

  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !a_mode && !a_data |=> bus_rdata == 32'h0);

endmodule

// File: tb/mbox_slot_regs_bench.sv
`timescale 1ns/1ps
module mbox_slot_regs_bench;
  localparam int NS = 32;
  localparam int MW = 8;
  localparam int AW = $clog2(NS) + 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] peer_ack = '0;
  logic [NS-1:0] ack_evt;
  logic [NS-1:0] tx_done;

  mbox_slot_regs #(.NUM_SLOTS(NS), .MSG_WORDS(MW)) u_mbox_slot_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .peer_ack(peer_ack),
    .ack_evt(ack_evt), .tx_done(tx_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit compare_on = 0;
  string cur_req = "R2";

  logic [31:0]   m_mode [NS];
  logic [31:0]   m_data [NS][MW];
  logic [31:0]   m_rd;
  logic [NS-1:0] m_evt;
  logic [NS-1:0] m_auto;
  int m_sl, m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) begin
        m_mode[k] = 32'h10;
        for (int w = 0; w < MW; w++) m_data[k][w] = 0;
      end
      m_rd = 0;
      m_evt = 0;
    end else begin
      m_sl = int'(bus_addr) / 16;
      m_wd = int'(bus_addr) % 16;
      if (m_wd == 0) m_rd = m_mode[m_sl];
      else if (m_wd <= MW) m_rd = m_data[m_sl][m_wd-1];
      else m_rd = 0;
      for (int k = 0; k < NS; k++) m_auto[k] = m_mode[k][0];
      if (bus_we) begin
        if (m_wd == 0) m_mode[m_sl] = bus_wdata;
        else if (m_wd <= MW) m_data[m_sl][m_wd-1] = bus_wdata;
      end
      for (int k = 0; k < NS; k++) begin
        m_evt[k] = 1'b0;
        if (peer_ack[k]) begin
          m_mode[k][7:4] = m_auto[k] ? 4'h1 : 4'h8;
          m_evt[k] = !m_auto[k];
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n && !finished) begin
      logic [NS-1:0] exp_done;
      for (int k = 0; k < NS; k++) exp_done[k] = (m_mode[k][7:4] == 4'h1);
      chk(cur_req, "model rdata", bus_rdata, m_rd);
      chk("R7", "model tx_done", tx_done, exp_done);
      chk("R6", "model ack_evt", ack_evt, m_evt);
    end
  end

  function automatic logic [AW-1:0] wa(input int slot, input int word);
    return AW'(slot * 16 + word);
  endfunction

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d, input logic [NS-1:0] ack);
    bus_we = we; bus_addr = a; bus_wdata = d; peer_ack = ack;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    step(1'b0, a, 32'h0, '0);
    chk(req, "read", bus_rdata, exp);
  endtask

  initial begin
    #(4 * 50000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    compare_on = 1;
    // R4 reset state
    chk("R4", "tx_done", tx_done, '1);
    chk("R4", "ack_evt", ack_evt, '0);
    cur_req = "R4";
    rd(wa(0, 0), 32'h10, "R4");
    rd(wa(31, 0), 32'h10, "R4");
    rd(wa(5, 4), 32'h0, "R4");

    // R1 R2 message words
    cur_req = "R2";
    for (int j = 0; j < MW; j++) step(1'b1, wa(3, j + 1), 32'hA500_0000 + j, '0);
    step(1'b1, wa(31, 8), 32'h1234_5678, '0);
    for (int j = 0; j < MW; j++) rd(wa(3, j + 1), 32'hA500_0000 + j, "R2");
    rd(wa(31, 8), 32'h1234_5678, "R1");

    // R10 slot independence
    rd(wa(2, 1), 32'h0, "R10");
    rd(wa(4, 1), 32'h0, "R10");
    rd(wa(3, 0), 32'h10, "R10");

    // R3 mode word read-modify-write
    cur_req = "R3";
    step(1'b1, wa(4, 0), 32'hDEAD_BE21, '0);
    rd(wa(4, 0), 32'hDEAD_BE21, "R3");
    chk("R7", "tx_done[4] busy", 32'(tx_done[4]), 32'h0);
    step(1'b1, wa(4, 0), 32'hDEAD_BE41, '0);
    rd(wa(4, 0), 32'hDEAD_BE41, "R3");

    // R5 automatic acknowledge
    cur_req = "R5";
    step(1'b0, wa(4, 0), 32'h0, NS'(1) << 4);
    chk("R5", "ack_evt", ack_evt, '0);
    chk("R7", "tx_done[4] idle", 32'(tx_done[4]), 32'h1);
    rd(wa(4, 0), 32'hDEAD_BE11, "R5");

    // R6 interrupt acknowledge
    cur_req = "R6";
    step(1'b1, wa(9, 0), 32'h0000_0020, '0);
    step(1'b0, wa(9, 0), 32'h0, NS'(1) << 9);
    chk("R6", "ack_evt pulse", ack_evt, NS'(1) << 9);
    step(1'b0, wa(9, 0), 32'h0, '0);
    chk("R6", "ack_evt drop", ack_evt, '0);
    rd(wa(9, 0), 32'h0000_0080, "R6");
    chk("R7", "tx_done[9] in ack", 32'(tx_done[9]), 32'h0);

    // R9 write and acknowledge in one cycle
    cur_req = "R9";
    step(1'b1, wa(12, 0), 32'h0000_0021, '0);
    step(1'b1, wa(12, 0), 32'h0000_0340, NS'(1) << 12);
    chk("R9", "ack_evt auto", ack_evt, '0);
    rd(wa(12, 0), 32'h0000_0310, "R9");
    step(1'b1, wa(13, 0), 32'h0000_0020, '0);
    step(1'b1, wa(13, 0), 32'h0000_0051, NS'(1) << 13);
    chk("R9", "ack_evt irq", ack_evt, NS'(1) << 13);
    rd(wa(13, 0), 32'h0000_0081, "R9");

    // R8 unused words
    cur_req = "R8";
    step(1'b1, wa(6, 9), 32'hFFFF_FFFF, '0);
    step(1'b1, wa(6, 15), 32'hFFFF_FFFF, '0);
    rd(wa(6, 9), 32'h0, "R8");
    rd(wa(6, 15), 32'h0, "R8");
    for (int j = 0; j < MW; j++) rd(wa(6, j + 1), 32'h0, "R8");
    rd(wa(6, 0), 32'h10, "R8");

    // R2 random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [NS-1:0] ack;
      ack = '0;
      if ($urandom_range(0, 3) == 0) ack[$urandom_range(0, NS - 1)] = 1'b1;
      step(1'($urandom_range(0, 1)), AW'($urandom), $urandom, ack);
    end
    step(1'b0, '0, 32'h0, '0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule